// File: doc/BRIEF.md
# Oversampling Averaging Accumulator

This block sits behind a 12-bit sampling converter and turns its sample stream into averaged results with extra resolution. Each incoming sample carries a 4-bit channel number. A 3-bit rate code picks how many samples make one average: 1, 4, 16, 64 or 256. The sum of those samples is shifted right by one bit per step of the code, so each step of four in the ratio adds one bit of resolution. The result is a 16-bit word with its channel number, marked by a one-cycle valid pulse.

Samples are only taken while a trigger credit is open. In multi-trigger mode each trigger pulse opens room for exactly one sample, so a full average needs as many triggers as the ratio. In single-trigger mode one pulse opens room for the whole burst of samples the ratio needs. Every channel keeps its own partial sum and sample count, so channels may be interleaved freely. Writing a new rate code throws away all partial averages and any open credit.

Top module: `osr_avg_accum`

## Requirements
- R1: With rate code 0, every accepted sample gives a result one clock after the sample cycle; the result is the 12-bit sample zero-extended to 16 bits.
- R2: Rate codes 1, 2, 3 and 4 average 4, 16, 64 and 256 accepted samples of one channel; the result is the sum of those samples shifted right by 1, 2, 3 and 4 bits, a (12+code)-bit value with all higher result bits zero.
- R3: Rate codes 5, 6 and 7 behave exactly like code 0.
- R4: With burst_mode = 0, a trig pulse opens credit for exactly one sample; further trig pulses before that sample do not add credit, and a sample that arrives with no credit open is ignored.
- R5: With burst_mode = 1, a trig pulse opens credit for as many samples as the ratio of the current code; samples beyond that credit are ignored.
- R6: When trig and a sample arrive in the same cycle, the sample uses the credit open before that cycle and the trigger then sets the credit to its reload value (1 or the ratio).
- R7: Each of the 16 channels keeps its own sum and count; samples of other channels in between do not change a channel's result.
- R8: In the cycle where rate_code differs from its value in the previous cycle, all partial sums, counts and the trigger credit are cleared, and a sample or trig in that cycle is ignored.
- R9: res_valid is high for one cycle per completed average, and res_chan gives the channel of the sample that completed it; no result appears otherwise.
- R10: After reset res_valid is 0, res_data is 0, no credit is open and the rate code in force is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | 12 | Unsigned sample value |
| smp_chan | input | 4 | Channel number of the sample |
| trig | input | 1 | Trigger pulse that opens sample credit |
| burst_mode | input | 1 | 0: one sample per trigger, 1: one burst per trigger |
| rate_code | input | 3 | Averaging ratio select (0..4, 5..7 as 0) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Averaged result, zero-extended |
| res_chan | output | 4 | Channel of the result |

## Verification
The bench drives interleaved channels under every rate code, including the 256-sample ratio at full-scale input, where a sum register one bit too narrow would wrap and a wrong shift would give a scaled result. It sends samples with no credit open, stacks several triggers before one sample in multi-trigger mode and overruns a single-trigger burst; a gate that counted triggers or ignored credit would produce stray results, which the scoreboard flags. It places a trigger and a sample in one cycle, where a wrong priority loses a sample, and changes the rate code in the middle of a partial average, where a design that kept old sums would return a result too large or too early.

// File: rtl/osr_avg_pkg.sv
package osr_avg_pkg;

  localparam int unsigned CODE_W = 3;

  // Number of base-4 steps a rate code selects; codes outside 1..max fall back to 0.
  function automatic int unsigned osr_log4(input int unsigned code, input int unsigned max_log4);
    if (code >= 1 && code <= max_log4) return code;
    return 0;
  endfunction

endpackage

// File: rtl/osr_rate_decode.sv
module osr_rate_decode
  import osr_avg_pkg::*;
#(
  parameter int unsigned MAX_LOG4 = 4,
  localparam int unsigned CNT_W   = 2 * MAX_LOG4,
  localparam int unsigned SH_W    = $clog2(MAX_LOG4 + 1)
) (
  input  logic [CODE_W-1:0] code,
  output logic [SH_W-1:0]   shift_o,
  output logic [CNT_W:0]    ratio_o,
  output logic [CNT_W-1:0]  last_idx_o
);

  int unsigned steps;
  logic [CNT_W:0] ratio_w;

  always_comb begin
    steps      = osr_log4(int'(code), MAX_LOG4);
    shift_o    = SH_W'(steps);
    ratio_w    = (CNT_W + 1)'(1) << (2 * steps);
    ratio_o    = ratio_w;
    last_idx_o = CNT_W'(ratio_w - 1'b1);
  end

endmodule

// File: rtl/osr_trig_gate.sv
module osr_trig_gate #(
  parameter int unsigned CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic           trig,
  input  logic           burst_mode,
  input  logic           flush,
  input  logic [CNT_W:0] ratio,
  output logic           accept,
  output logic           credit_nz
);

  logic [CNT_W:0] credit_q;

  assign credit_nz = (credit_q != '0);
  assign accept    = smp_valid && credit_nz && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      credit_q <= '0;
    end else if (trig) begin
      credit_q <= burst_mode ? ratio : (CNT_W + 1)'(1);
    end else if (accept) begin
      credit_q <= credit_q - 1'b1;
    end
  end

endmodule

// File: rtl/osr_chan_store.sv
module osr_chan_store #(
  parameter int unsigned CH_W  = 4,
  parameter int unsigned ACC_W = 20,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned N_CH = 1 << CH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  chan,
  input  logic             wr_en,
  input  logic [ACC_W-1:0] wr_acc,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             retire,
  input  logic             clr_all,
  output logic [ACC_W-1:0] rd_acc,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_live
);

  // Sum and count arrays carry no reset so they map to distributed RAM;
  // the live vector marks which entries hold a partial average.
  logic [ACC_W-1:0] acc_mem [N_CH];
  logic [CNT_W-1:0] cnt_mem [N_CH];
  logic [N_CH-1:0]  live_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      acc_mem[chan] <= wr_acc;
      cnt_mem[chan] <= wr_cnt;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_live
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        live_q[g] <= 1'b0;
      end else if (chan == CH_W'(g)) begin
        if (wr_en)       live_q[g] <= 1'b1;
        else if (retire) live_q[g] <= 1'b0;
      end
    end
  end

  assign rd_live = live_q[chan];
  assign rd_acc  = rd_live ? acc_mem[chan] : '0;
  assign rd_cnt  = rd_live ? cnt_mem[chan] : '0;

endmodule

// File: rtl/osr_avg_accum.sv
module osr_avg_accum
  import osr_avg_pkg::*;
#(
  parameter int unsigned SMP_W    = 12,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned MAX_LOG4 = 4,
  localparam int unsigned CNT_W   = 2 * MAX_LOG4,
  localparam int unsigned ACC_W   = SMP_W + CNT_W,
  localparam int unsigned SH_W    = $clog2(MAX_LOG4 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic              trig,
  input  logic              burst_mode,
  input  logic [CODE_W-1:0] rate_code,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [CH_W-1:0]   res_chan
);

  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  logic [SH_W-1:0]   shift;
  logic [CNT_W:0]    ratio;
  logic [CNT_W-1:0]  last_idx;
  logic              accept;
  logic              credit_nz;
  logic [ACC_W-1:0]  rd_acc;
  logic [CNT_W-1:0]  rd_cnt;
  logic              rd_live;
  logic [ACC_W-1:0]  sum;
  logic              done;

  // A code that differs from the one in force flushes all state this cycle.
  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= rate_code;
  end
  assign code_chg = (rate_code != code_q);

  osr_rate_decode #(.MAX_LOG4(MAX_LOG4)) u_decode (
    .code       (code_q),
    .shift_o    (shift),
    .ratio_o    (ratio),
    .last_idx_o (last_idx)
  );

  osr_trig_gate #(.CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .trig       (trig),
    .burst_mode (burst_mode),
    .flush      (code_chg),
    .ratio      (ratio),
    .accept     (accept),
    .credit_nz  (credit_nz)
  );

  assign sum  = rd_acc + ACC_W'(smp_data);
  assign done = (rd_cnt == last_idx);

  osr_chan_store #(.CH_W(CH_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .chan    (smp_chan),
    .wr_en   (accept && !done),
    .wr_acc  (sum),
    .wr_cnt  (rd_cnt + 1'b1),
    .retire  (accept && done),
    .clr_all (code_chg),
    .rd_acc  (rd_acc),
    .rd_cnt  (rd_cnt),
    .rd_live (rd_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      res_valid <= accept && done;
      if (accept && done) begin
        res_data <= RES_W'(sum >> shift);
        res_chan <= smp_chan;
      end
    end
  end

endmodule

// File: rtl/osr_avg_accum_chk.sv
module osr_avg_accum_chk
  import osr_avg_pkg::*;
#(
  parameter int unsigned SMP_W    = 12,
  parameter int unsigned CH_W     = 4,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned MAX_LOG4 = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [CH_W-1:0]   smp_chan,
  input logic [CODE_W-1:0] rate_code,
  input logic [CODE_W-1:0] code_q,
  input logic              credit_nz,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic [CH_W-1:0]   res_chan
);

  function automatic int unsigned res_bits(input logic [CODE_W-1:0] c);
    return SMP_W + osr_log4(int'(c), MAX_LOG4);
  endfunction

  // R9: a result only follows a sample cycle
  a_r9_needs_sample: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(smp_valid));

  // R9: result channel is the channel of the completing sample
  a_r9_chan_match: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_chan == $past(smp_chan));

  // R4: no result without credit open in the sample cycle
  a_r4_needs_credit: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(credit_nz));

  // R8: a rate change cycle never completes an average
  a_r8_change_drops: assert property (@(posedge clk) disable iff (rst)
    (rate_code != code_q) |=> !res_valid);

  // R2: bits above the code's result width stay zero
  a_r2_width: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((32'(res_data) >> res_bits($past(code_q))) == 0));

endmodule

bind osr_avg_accum osr_avg_accum_chk #(
  .SMP_W(SMP_W), .CH_W(CH_W), .RES_W(RES_W), .MAX_LOG4(MAX_LOG4)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .rate_code (rate_code),
  .code_q    (code_q),
  .credit_nz (credit_nz),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_chan  (res_chan)
);

// File: tb/osr_avg_accum_bench.sv
module osr_avg_accum_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [3:0]  smp_chan = '0;
  logic        trig = 1'b0;
  logic        burst_mode = 1'b0;
  logic [2:0]  rate_code = '0;
  logic        res_valid;
  logic [15:0] res_data;
  logic [3:0]  res_chan;

  always #5 clk = ~clk;

  osr_avg_accum u_osr_avg_accum (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_chan(smp_chan), .trig(trig), .burst_mode(burst_mode),
    .rate_code(rate_code), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan)
  );

  typedef struct {
    int    chan;
    int    data;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  // Reference model state, from the requirements
  int m_code = 0;
  int m_credit = 0;
  int m_acc [16];
  int m_cnt [16];

  function automatic int m_steps();
    return (m_code >= 1 && m_code <= 4) ? m_code : 0;
  endfunction

  function automatic int m_ratio();
    return 1 << (2 * m_steps());
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 16; i++) begin
      m_acc[i] = 0;
      m_cnt[i] = 0;
    end
    m_credit = 0;
  endtask

  // One clock: drive inputs, update the model, advance.
  task automatic cyc(input bit v, input int d, input int c, input bit t, input string tag);
    bit acc_ok;
    smp_valid = v;
    smp_data  = 12'(d);
    smp_chan  = 4'(c);
    trig      = t;
    acc_ok = v && (m_credit > 0);
    if (acc_ok) begin
      m_acc[c] += d;
      m_cnt[c] += 1;
      if (m_cnt[c] == m_ratio()) begin
        exp_q.push_back('{chan: c, data: m_acc[c] >> m_steps(), tag: tag});
        m_acc[c] = 0;
        m_cnt[c] = 0;
      end
    end
    if (t) m_credit = burst_mode ? m_ratio() : 1;
    else if (acc_ok) m_credit -= 1;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    trig      = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, "");
  endtask

  // Rate change cycle; sample and trigger in it are ignored (R8).
  task automatic set_code(input int code, input bit v, input bit t);
    rate_code = 3'(code);
    smp_valid = v;
    smp_data  = 12'h7FF;
    trig      = t;
    m_code = code;
    m_clear();
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    trig      = 1'b0;
  endtask

  // Multi-trigger sample: trigger one cycle, sample the next.
  task automatic trig_smp(input int d, input int c, input string tag);
    cyc(0, 0, 0, 1, tag);
    cyc(1, d, c, 0, tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9/R4/R5/R8 unexpected result: actual ch=%0d data=0x%0h expected none",
                 res_chan, res_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(res_chan) != e.chan || int'(res_data) != e.data) begin
          errors++;
          $display("FAIL %s: actual ch=%0d data=0x%0h expected ch=%0d data=0x%0h",
                   e.tag, res_chan, res_data, e.chan, e.data);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_data !== 16'h0) begin
      errors++;
      $display("FAIL R10 reset: actual valid=%b data=0x%0h expected valid=0 data=0x0",
               res_valid, res_data);
    end
    @(posedge clk);
    #1;

    // R10: no credit after reset, sample ignored
    cyc(1, 12'h123, 0, 0, "R10");
    // R1: pass-through
    trig_smp(12'hABC, 3, "R1 passthrough ch3");
    trig_smp(12'hFFF, 15, "R1 full scale ch15");
    // R4: stacked triggers give one sample only
    cyc(0, 0, 0, 1, "R4");
    cyc(0, 0, 0, 1, "R4");
    cyc(1, 12'h055, 6, 0, "R4 one credit");
    cyc(1, 12'h066, 6, 0, "R4 ignored");
    // R6: trigger and sample in one cycle
    cyc(0, 0, 0, 1, "R6");
    cyc(1, 12'h111, 4, 1, "R6 same-cycle first");
    cyc(1, 12'h222, 4, 0, "R6 reloaded credit");
    cyc(1, 12'h333, 4, 0, "R6 ignored");
    idle(2);

    // R3: unused codes act as pass-through
    set_code(5, 0, 0);
    trig_smp(12'h5A5, 9, "R3 code5");
    set_code(7, 0, 0);
    trig_smp(12'h00F, 2, "R3 code7");
    idle(2);

    // R2 / R7: code 1, interleaved channels, multi-trigger
    set_code(1, 0, 0);
    for (int i = 0; i < 4; i++) begin
      trig_smp(100 + i * 7, 2, "R2 code1 ch2");
      trig_smp(4000 - i * 3, 7, "R7 interleave ch7");
    end
    idle(2);

    // R5: single-trigger burst, code 2, then overrun
    burst_mode = 1'b1;
    set_code(2, 0, 0);
    cyc(0, 0, 0, 1, "R5");
    for (int i = 0; i < 16; i++) cyc(1, i * 100 + 3, 1, 0, "R5 burst code2 ch1");
    cyc(1, 12'h7FF, 1, 0, "R5 overrun ignored");
    cyc(1, 12'h7FF, 1, 0, "R5 overrun ignored");
    idle(2);

    // R2: code 3 burst with two channels interleaved
    set_code(3, 0, 0);
    cyc(0, 0, 0, 1, "R2");
    for (int i = 0; i < 64; i++) cyc(1, (i * 61) % 4096, (i % 2) ? 11 : 12, 0, "R2 code3");
    cyc(0, 0, 0, 1, "R2");
    for (int i = 0; i < 64; i++) cyc(1, (i * 61 + 17) % 4096, (i % 2) ? 11 : 12, 0, "R2 code3 second");
    idle(2);

    // R2: code 4 at full scale
    set_code(4, 0, 0);
    cyc(0, 0, 0, 1, "R2");
    for (int i = 0; i < 256; i++) cyc(1, 12'hFFF, 5, 0, "R2 code4 full scale");
    idle(2);

    // R8: rate change mid-average discards partial sums and credit
    burst_mode = 1'b0;
    set_code(1, 0, 0);
    trig_smp(12'hF00, 0, "R8 partial");
    trig_smp(12'hF00, 0, "R8 partial");
    cyc(0, 0, 0, 1, "R8");
    set_code(2, 1, 1);
    cyc(1, 12'h7FF, 0, 0, "R8 credit cleared");
    set_code(1, 0, 0);
    for (int i = 0; i < 4; i++) trig_smp(8 + i, 0, "R8 fresh average");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule